// File: doc/BRIEF.md
# Soda Vending Controller With Change

This block is the sequencing core of a soda machine. It takes one-cycle event pulses for a quarter, a dime, a nickel and a soda request. It keeps the inserted credit in 5-cent units. When a request arrives and the credit is at least the 50-cent price, it issues a one-cycle dispense pulse. It then pays back the excess as a train of one-cycle coin pulses, one coin per cycle, with dimes first and a final nickel when one is needed. Coin checking and the coin and can mechanics are handled elsewhere.

A build-time parameter selects how money inserted beyond the price is treated. In the default mode, extra coins go on raising the credit up to a 70-cent ceiling and come back as change. In tip mode, the change is fixed on the cycle the credit first reaches the price, and any later coins are kept.

All event pins are plain pulses with no back-pressure. An input pulse that the block cannot use in a given cycle is dropped. No handshake exists at either edge, so the environment must not expect a dropped coin to be retried. Events come from a debounced front end, and each output pulse drives an actuator directly.

Top module: `soda_vend_ctrl`

## Requirements
- R1: After reset, all three outputs are low and the credit is zero, so a soda request given straight after reset produces no output.
- R2: While collecting, a single coin pulse adds its value to the credit: quarter 5 units, dime 2 units, nickel 1 unit, where one unit is 5 cents.
- R3: A soda request with less than 10 units (50 cents) of credit produces no output and leaves the credit unchanged.
- R4: A soda request with at least 10 units of credit drives `soda_o` high for exactly one cycle. That cycle is the one after the cycle in which the request was sampled.
- R5: The change equals the credit minus 10 units. It is paid in the cycles directly after the dispense pulse, one coin per cycle, with as many dimes as possible first and then at most one nickel.
- R6: In any cycle, at most one of `soda_o`, `ret_dime_o` and `ret_nickel_o` is high.
- R7: Coin and request pulses sampled while change is still owed (from the dispense cycle until the cycle before the last coin pulse) are ignored.
- R8: A cycle in which more than one of the four input pins is high is ignored entirely.
- R9: With `TIP_MODE` = 0, coins keep being accepted after the price is reached, as long as the credit stays at or below 14 units (70 cents). A coin that would take the credit above 14 units is dropped.
- R10: With `TIP_MODE` = 1, once the credit has reached 10 units, further coins do not change it, so the change stays fixed at the amount owed when the price was first reached.
- R11: Once the dispense pulse has been issued, the credit is zero, so a later request with no new coins produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coin_quarter_i | input | 1 | One-cycle pulse: a quarter was inserted |
| coin_dime_i | input | 1 | One-cycle pulse: a dime was inserted |
| coin_nickel_i | input | 1 | One-cycle pulse: a nickel was inserted |
| soda_req_i | input | 1 | One-cycle pulse: the customer asks for a soda |
| soda_o | output | 1 | One-cycle pulse: release one soda |
| ret_dime_o | output | 1 | One-cycle pulse: return one dime |
| ret_nickel_o | output | 1 | One-cycle pulse: return one nickel |

## Verification
The main function is exercised with coin sequences that reach the price exactly, with change owed of zero, one, three and four units, and with a run of nickels. These separate the coin values, the dime-then-nickel ordering and the price comparison. Sequences that keep inserting coins after the price is reached are run on a default instance and on a tip-mode instance side by side. This tells the credit ceiling apart from the freeze, and a quarter that would break the ceiling checks the drop rule. Directed runs then pile simultaneous pins together, insert coins while change is being paid, and request again after a purchase. Those runs separate ignored events from credited ones and confirm that the credit is cleared.

// File: rtl/soda_vend_pkg.sv
package soda_vend_pkg;

  // Decoded input event for one cycle; EV_NONE also covers illegal combinations.
  typedef enum logic [2:0] {
    EV_NONE    = 3'd0,
    EV_NICKEL  = 3'd1,
    EV_DIME    = 3'd2,
    EV_QUARTER = 3'd3,
    EV_REQUEST = 3'd4
  } vend_event_e;

  // Controller phase: taking money, or paying change back.
  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_PAY     = 1'b1
  } vend_state_e;

  // Width needed to hold a count up to and including max_val.
  function automatic int units_width(input int max_val);
    int w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction

endpackage

// File: rtl/vend_event_decode.sv
module vend_event_decode
  import soda_vend_pkg::*;
#(
  parameter int CW            = 4,
  parameter int QUARTER_UNITS = 5,
  parameter int DIME_UNITS    = 2
) (
  input  logic          quarter_i,
  input  logic          dime_i,
  input  logic          nickel_i,
  input  logic          request_i,
  output vend_event_e   event_o,
  output logic [CW-1:0] coin_units_o
);

  localparam logic [CW-1:0] QUARTER_W = CW'(QUARTER_UNITS);
  localparam logic [CW-1:0] DIME_W    = CW'(DIME_UNITS);
  localparam logic [CW-1:0] NICKEL_W  = CW'(1);

  logic [3:0] pins;
  assign pins = {quarter_i, dime_i, nickel_i, request_i};

  // Exactly one pin high gives an event; zero or several give nothing.
  always_comb begin
    event_o = EV_NONE;
    unique case (pins)
      4'b1000: event_o = EV_QUARTER;
      4'b0100: event_o = EV_DIME;
      4'b0010: event_o = EV_NICKEL;
      4'b0001: event_o = EV_REQUEST;
      default: event_o = EV_NONE;
    endcase
  end

  always_comb begin
    case (event_o)
      EV_QUARTER: coin_units_o = QUARTER_W;
      EV_DIME:    coin_units_o = DIME_W;
      EV_NICKEL:  coin_units_o = NICKEL_W;
      default:    coin_units_o = '0;
    endcase
  end

  // Illegal pin mixes never leak through as an event.
  always_comb begin
    AST_MULTI_PIN_DROPPED: assert (($countones(pins) > 1) -> (event_o == EV_NONE)); // R8
  end

endmodule

// File: rtl/vend_credit.sv
module vend_credit #(
  parameter int CW          = 4,
  parameter int PRICE_UNITS = 10,
  parameter int CAP_UNITS   = 14,
  parameter bit TIP_MODE    = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          collecting_i,
  input  logic          coin_valid_i,
  input  logic [CW-1:0] coin_units_i,
  input  logic          clear_i,
  output logic [CW-1:0] credit_o,
  output logic          at_price_o
);

  localparam int              CW1     = CW + 1;
  localparam logic [CW-1:0]   PRICE_W = CW'(PRICE_UNITS);
  localparam logic [CW1-1:0]  CAP_W   = CW1'(CAP_UNITS);

  logic [CW-1:0]  credit_q;
  logic [CW1-1:0] sum;
  logic           room;
  logic           take;

  assign sum        = {1'b0, credit_q} + {1'b0, coin_units_i};
  assign at_price_o = (credit_q >= PRICE_W);

  // The mode picks the rule that decides whether a coin still counts.
  generate
    if (TIP_MODE) begin : g_tip
      // The amount owed is frozen once the price is met; extra money is kept.
      assign room = !at_price_o;
    end else begin : g_refund
      // Extra money stays in the credit and is refunded, up to the ceiling.
      assign room = (sum <= CAP_W);
    end
  endgenerate

  assign take = collecting_i && coin_valid_i && room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit_q <= '0;
    end else if (clear_i) begin
      credit_q <= '0;
    end else if (take) begin
      credit_q <= sum[CW-1:0];
    end
  end

  assign credit_o = credit_q;

  AST_CREDIT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, credit_q} <= CAP_W)); // R9

  AST_HOLD_WHILE_PAYING: assert property (@(posedge clk) disable iff (!rst_n)
    (!collecting_i) |=> (credit_q == $past(credit_q))); // R7

  generate
    if (TIP_MODE) begin : g_tip_check
      AST_TIP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (at_price_o && !clear_i) |=> (credit_q == $past(credit_q))); // R10
    end
  endgenerate

endmodule

// File: rtl/vend_payout.sv
module vend_payout #(
  parameter int CW         = 4,
  parameter int DIME_UNITS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_amt_i,
  output logic          busy_o,
  output logic          dime_o,
  output logic          nickel_o
);

  localparam logic [CW-1:0] DIME_W   = CW'(DIME_UNITS);
  localparam logic [CW-1:0] NICKEL_W = CW'(1);

  logic [CW-1:0] owed_q;
  logic          busy_q;
  logic          dime_q;
  logic          nickel_q;
  logic          pick_dime;
  logic [CW-1:0] owed_after;

  // Largest coin first: a dime whenever one still fits, else a nickel.
  assign pick_dime  = (owed_q >= DIME_W);
  assign owed_after = pick_dime ? (owed_q - DIME_W) : (owed_q - NICKEL_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q   <= '0;
      busy_q   <= 1'b0;
      dime_q   <= 1'b0;
      nickel_q <= 1'b0;
    end else begin
      dime_q   <= 1'b0;
      nickel_q <= 1'b0;
      if (load_i) begin
        owed_q <= load_amt_i;
        busy_q <= (load_amt_i != '0);
      end else if (busy_q) begin
        dime_q   <= pick_dime;
        nickel_q <= !pick_dime;
        owed_q   <= owed_after;
        busy_q   <= (owed_after != '0);
      end
    end
  end

  assign busy_o   = busy_q;
  assign dime_o   = dime_q;
  assign nickel_o = nickel_q;

  AST_OWED_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !load_i) |=> (owed_q < $past(owed_q))); // R5

  AST_NICKEL_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    nickel_q |-> !busy_q); // R5

  AST_NO_RELOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !busy_q); // R7

endmodule

// File: rtl/soda_vend_ctrl.sv
module soda_vend_ctrl
  import soda_vend_pkg::*;
#(
  parameter int PRICE_UNITS   = 10,
  parameter int QUARTER_UNITS = 5,
  parameter int DIME_UNITS    = 2,
  parameter bit TIP_MODE      = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic coin_quarter_i,
  input  logic coin_dime_i,
  input  logic coin_nickel_i,
  input  logic soda_req_i,
  output logic soda_o,
  output logic ret_dime_o,
  output logic ret_nickel_o
);

  // Highest credit: one unit short of the price, plus the largest coin.
  localparam int            CAP_UNITS = PRICE_UNITS - 1 + QUARTER_UNITS;
  localparam int            CW        = units_width(CAP_UNITS);
  localparam logic [CW-1:0] PRICE_W   = CW'(PRICE_UNITS);

  vend_event_e   ev;
  vend_state_e   state;
  logic [CW-1:0] coin_units;
  logic [CW-1:0] credit;
  logic          at_price;
  logic          coin_valid;
  logic          collecting;
  logic          accept;
  logic          pay_busy;
  logic          soda_q;
  logic [CW-1:0] change_amt;

  vend_event_decode #(
    .CW            (CW),
    .QUARTER_UNITS (QUARTER_UNITS),
    .DIME_UNITS    (DIME_UNITS)
  ) u_decode (
    .quarter_i    (coin_quarter_i),
    .dime_i       (coin_dime_i),
    .nickel_i     (coin_nickel_i),
    .request_i    (soda_req_i),
    .event_o      (ev),
    .coin_units_o (coin_units)
  );

  assign state      = pay_busy ? ST_PAY : ST_COLLECT;
  assign collecting = (state == ST_COLLECT);
  assign coin_valid = (ev == EV_QUARTER) || (ev == EV_DIME) || (ev == EV_NICKEL);
  assign accept     = collecting && (ev == EV_REQUEST) && at_price;
  assign change_amt = credit - PRICE_W;

  vend_credit #(
    .CW          (CW),
    .PRICE_UNITS (PRICE_UNITS),
    .CAP_UNITS   (CAP_UNITS),
    .TIP_MODE    (TIP_MODE)
  ) u_credit (
    .clk          (clk),
    .rst_n        (rst_n),
    .collecting_i (collecting),
    .coin_valid_i (coin_valid),
    .coin_units_i (coin_units),
    .clear_i      (accept),
    .credit_o     (credit),
    .at_price_o   (at_price)
  );

  vend_payout #(
    .CW         (CW),
    .DIME_UNITS (DIME_UNITS)
  ) u_payout (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept),
    .load_amt_i (change_amt),
    .busy_o     (pay_busy),
    .dime_o     (ret_dime_o),
    .nickel_o   (ret_nickel_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soda_q <= 1'b0;
    else        soda_q <= accept;
  end

  assign soda_o = soda_q;

  AST_SODA_IS_PAID: assert property (@(posedge clk) disable iff (!rst_n)
    soda_q |-> ($past(credit) >= PRICE_W)); // R4

  AST_SODA_NOT_DURING_PAY: assert property (@(posedge clk) disable iff (!rst_n)
    soda_q |-> !$past(pay_busy)); // R7

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({soda_q, ret_dime_o, ret_nickel_o})); // R6

  AST_CREDIT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    soda_q |-> (credit == '0)); // R11

endmodule

// File: tb/test_soda_vend_ctrl.sv
module test_soda_vend_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic q_i = 1'b0, d_i = 1'b0, n_i = 1'b0, r_i = 1'b0;
  logic so_n, di_n, ni_n;
  logic so_t, di_t, ni_t;
  logic [2:0] obs_n, obs_t;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  soda_vend_ctrl #(.TIP_MODE(1'b0)) i_soda_vend_ctrl (
    .clk(clk), .rst_n(rst_n),
    .coin_quarter_i(q_i), .coin_dime_i(d_i), .coin_nickel_i(n_i), .soda_req_i(r_i),
    .soda_o(so_n), .ret_dime_o(di_n), .ret_nickel_o(ni_n)
  );

  soda_vend_ctrl #(.TIP_MODE(1'b1)) i_soda_vend_ctrl_tip (
    .clk(clk), .rst_n(rst_n),
    .coin_quarter_i(q_i), .coin_dime_i(d_i), .coin_nickel_i(n_i), .soda_req_i(r_i),
    .soda_o(so_t), .ret_dime_o(di_t), .ret_nickel_o(ni_t)
  );

  // Vector: [19:8] six 2-bit coin slots (slot0 first; 1=N 2=D 3=Q 0=none),
  // [7:4] default-mode result, [3:0] tip-mode result,
  // each result = {soda, dimes[1:0], nickel}.
  localparam logic [19:0] VEC [10] = '{
    20'h00F88,  // Q Q: exact price
    20'h06B88,  // Q D D N: exact price
    20'h0AB99,  // Q D D D: one nickel back
    20'h03F88,  // Q Q Q: third quarter over the ceiling
    20'h0AFC8,  // Q Q D D: two dimes back, tip keeps them
    20'h3AABB,  // D D D D Q: dime and nickel back
    20'h09FB8,  // Q Q N D: refund vs tip
    20'h0BDB9,  // N Q Q D: tip freezes a nickel of change
    20'h00600,  // D N: below price
    20'hD5588   // five nickels then a quarter
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive {q,d,n,r} for one cycle, then capture the outputs of that edge.
  task automatic tick(input logic [3:0] pins);
    {q_i, d_i, n_i, r_i} = pins;
    @(negedge clk);
    obs_n = {so_n, di_n, ni_n};
    obs_t = {so_t, di_t, ni_t};
    {q_i, d_i, n_i, r_i} = 4'b0000;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(4'b0000);
    tick(4'b0000);
    rst_n = 1'b1;
    tick(4'b0000);
  endtask

  function automatic logic [17:0] exp_stream(input logic [3:0] e);
    logic [17:0] s;
    int nd;
    s = '0;
    if (e[3]) begin
      s[2:0] = 3'b100;
      nd = int'(e[2:1]);
      for (int k = 1; k <= nd; k++) s[3*k +: 3] = 3'b010;
      if (e[0]) s[3*(nd+1) +: 3] = 3'b001;
    end
    return s;
  endfunction

  logic [17:0] act_n, act_t;

  // Request now and record six cycles of output from both instances.
  task automatic request_and_watch();
    act_n = '0;
    act_t = '0;
    tick(4'b0001);
    act_n[2:0] = obs_n;
    act_t[2:0] = obs_t;
    for (int k = 1; k < 6; k++) begin
      tick(4'b0000);
      act_n[3*k +: 3] = obs_n;
      act_t[3*k +: 3] = obs_t;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    obs_n = '0;
    obs_t = '0;
    @(negedge clk);
    do_reset();

    // R1: quiet after reset, and a request with no credit does nothing.
    check(obs_n == 3'b000 && obs_t == 3'b000, "R1 reset outputs", {obs_n, obs_t}, 0);
    request_and_watch();
    check(act_n == '0 && act_t == '0, "R1 request after reset", {act_n, act_t}, 0);

    // Vector walk: R2 coin values, R3/R4/R5 dispense and change, R9 ceiling, R10 tip.
    for (int v = 0; v < 10; v++) begin
      do_reset();
      for (int s = 0; s < 6; s++) begin
        logic [1:0] code;
        code = VEC[v][8 + 2*s +: 2];
        if (code == 2'd3)      tick(4'b1000);
        else if (code == 2'd2) tick(4'b0100);
        else if (code == 2'd1) tick(4'b0010);
      end
      request_and_watch();
      check(act_n == exp_stream(VEC[v][7:4]), $sformatf("R2 R4 R5 R9 vector %0d default", v),
            32'(act_n), 32'(exp_stream(VEC[v][7:4])));
      check(act_t == exp_stream(VEC[v][3:0]), $sformatf("R2 R4 R5 R10 vector %0d tip", v),
            32'(act_t), 32'(exp_stream(VEC[v][3:0])));
      check(act_n != '0 || VEC[v][7] == 1'b0, $sformatf("R3 vector %0d", v), 32'(act_n), 0);
    end

    // R8: several pins in one cycle are dropped.
    do_reset();
    tick(4'b1100);
    tick(4'b1110);
    tick(4'b1001);
    tick(4'b1000);  // credit 5 units if the mixes were dropped
    request_and_watch();
    check(act_n == '0 && act_t == '0, "R8 mixed pins ignored", {act_n, act_t}, 0);
    // R3: the short request left credit alone; one more quarter reaches the price.
    tick(4'b1000);
    request_and_watch();
    check(act_n == 18'h4 && act_t == 18'h4, "R3 credit kept after short request", {act_n, act_t}, 18'h4);

    // R6: a full payout never overlaps pulses; checked cycle by cycle.
    do_reset();
    tick(4'b0100); tick(4'b0100); tick(4'b0100); tick(4'b0100); tick(4'b1000);
    begin
      int bad;
      bad = 0;
      tick(4'b0001);
      if ($countones(obs_n) > 1 || $countones(obs_t) > 1) bad++;
      for (int k = 0; k < 4; k++) begin
        tick(4'b0000);
        if ($countones(obs_n) > 1 || $countones(obs_t) > 1) bad++;
      end
      check(bad == 0, "R6 one pulse per cycle", bad, 0);
    end

    // R7 and R11: coins during payout ignored; credit zero afterwards.
    do_reset();
    tick(4'b1000); tick(4'b1000); tick(4'b0100); tick(4'b0100);
    tick(4'b0001);
    check(obs_n == 3'b100, "R4 soda in refund case", obs_n, 3'b100);
    tick(4'b1000);
    check(obs_n == 3'b010, "R5 first dime", obs_n, 3'b010);
    tick(4'b1000);
    check(obs_n == 3'b010, "R5 second dime", obs_n, 3'b010);
    request_and_watch();
    check(act_n == '0, "R7 R11 coins during payout dropped", act_n, 0);
    // Tip instance owed nothing, so it was collecting again and took both quarters.
    check(act_t == 18'h4, "R7 tip instance collecting again", act_t, 18'h4);

    // R11: after a purchase, one quarter alone must not buy another soda.
    do_reset();
    tick(4'b1000); tick(4'b1000);
    request_and_watch();
    tick(4'b1000);
    request_and_watch();
    check(act_n == '0 && act_t == '0, "R11 credit cleared", {act_n, act_t}, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule